// File: doc/BRIEF.md
# Reset Request Bounce Filter

This block cleans up a reset request that arrives from a noisy source, such as a mechanical push button that chatters or a board trace that picks up coupled noise. Its result goes to the input of an asynchronous reset synchronizer. It must not drive the reset pins of functional flip-flops. The filter runs on a free-running clock. That clock must not depend on the reset being filtered, and it keeps toggling while reset is asserted.

The raw request first passes through a two-stage metastability synchronizer. A parameter normalizes the raw request's polarity so that logic 1 means "reset requested". The filtered output follows a new level only after the synchronized request has held that level for `FILTER_CYCLES` consecutive clock cycles. This rule applies in both directions, so chatter toward assertion and chatter toward release are both rejected.

A parameter selects how the window is built. The first choice is a saturating-compare counter. The second is a shift pipeline of `FILTER_CYCLES` flops. An active-low power-on clear forces the output to the asserted level.

Top module: `rst_bounce_filter`

## Requirements
- R1: While `por_n_i` is low at a rising clock edge, `rst_req_o` is 1 (asserted) after that edge. After `por_n_i` rises, `rst_req_o` stays 1 until the request has been seen released for the full window.
- R2: With `RAW_ACTIVE_LOW` = 1 (the default), a raw level of 0 on `raw_rst_i` means reset requested and a raw level of 1 means released. `rst_req_o` is active high (1 = reset asserted).
- R3: While `rst_req_o` is 1, any release pulse on `raw_rst_i` of `FILTER_CYCLES`-1 cycles or fewer leaves `rst_req_o` unchanged. This also holds for a train of such pulses.
- R4: While `rst_req_o` is 0, any assertion pulse on `raw_rst_i` of `FILTER_CYCLES`-1 cycles or fewer leaves `rst_req_o` unchanged.
- R5: After a release level has been held on `raw_rst_i`, `rst_req_o` falls no sooner than `FILTER_CYCLES` cycles and no later than `FILTER_CYCLES`+3 cycles after the raw change.
- R6: `rst_req_o` changes only after the synchronized request has differed from it for at least `FILTER_CYCLES`-1 consecutive prior samples. It never toggles on two consecutive cycles.
- R7: After an assertion level has been held on `raw_rst_i`, `rst_req_o` rises no sooner than `FILTER_CYCLES` cycles and no later than `FILTER_CYCLES`+3 cycles after the raw change.
- R8: The counter window (`WINDOW` = WIN_COUNT) and the shift window (`WINDOW` = WIN_SHIFT) make the same accept and reject decisions for the same raw input. Their output levels agree once the input has been stable for the window plus latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock, independent of the reset being filtered |
| por_n_i | input | 1 | Synchronous active-low power-on clear; forces the output asserted |
| raw_rst_i | input | 1 | Noisy raw reset request, polarity set by `RAW_ACTIVE_LOW` |
| rst_req_o | output | 1 | Filtered reset request, active high, for a downstream reset synchronizer |

## Verification
The filter is driven with single short pulses of length 1, half the window and one less than the window, in both polarities. These patterns separate a correct full-window rule from one that is off by one or that triggers on a partial run. Trains of back-to-back sub-window pulses check that a partial run is discarded when the input returns to the output level, so that runs cannot accumulate across bounces. Long held levels in both directions measure the acceptance latency against the lower and upper bounds. A power-on clear applied in mid-operation checks the forced asserted level. Both window implementations run side by side on the same stimulus so that any difference between them shows.

// File: rtl/rbf_pkg.sv
// Package: shared types for the reset bounce filter.
package rbf_pkg;

    // Selects how the acceptance window is implemented.
    typedef enum logic {
        WIN_SHIFT = 1'b0,   // shift pipeline of FILTER_CYCLES flops
        WIN_COUNT = 1'b1    // run-length counter
    } rbf_win_e;

endpackage

// File: rtl/rbf_in_sync.sv
// Module: rbf_in_sync
// Brings the raw reset request into the clock domain through a chain of
// STAGES flops and normalizes it so that 1 means "reset requested".
// Assumes: clk_i is free running; por_n_i is a synchronous active-low clear
// that preloads every stage with the requested level.
module rbf_in_sync #(
    parameter int unsigned STAGES     = 2,
    parameter bit          ACTIVE_LOW = 1'b1
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic raw_i,
    output logic req_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic              raw_norm;
    logic [STAGES-1:0] chain_q;

    // Map the raw pin to the internal "1 = requested" convention.
    assign raw_norm = ACTIVE_LOW ? ~raw_i : raw_i;

    // Shift the normalized request through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LAST-1:0], raw_norm};
        end
    end

    assign req_o = chain_q[LAST];

endmodule

// File: rtl/rbf_cnt_win.sv
// Module: rbf_cnt_win
// Counter-based acceptance window. The counter clears whenever the request
// matches the output. The output takes the new level when the counter has
// reached CYCLES-1 and the request still differs.
// Assumes: CYCLES >= 2; lvl_i is already synchronous to clk_i.
module rbf_cnt_win #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic lvl_i,
    output logic filt_o
);

    localparam int unsigned CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             filt_q;
    logic             differs;

    assign differs = (lvl_i != filt_q);

    // Count consecutive differing samples and flip the output at the window end.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (!differs) begin
            cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= lvl_i;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

endmodule

// File: rtl/rbf_shift_win.sv
// Module: rbf_shift_win
// Shift-pipeline acceptance window. The last CYCLES samples are held in a
// shift register. The output moves only when every stage agrees on a level
// that differs from the current output.
// Assumes: CYCLES >= 2; lvl_i is already synchronous to clk_i.
module rbf_shift_win #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic lvl_i,
    output logic filt_o
);

    logic [CYCLES-1:0] hist_q;
    logic              filt_q;
    logic              all_hi;
    logic              all_lo;

    assign all_hi = &hist_q;
    assign all_lo = ~|hist_q;

    // Keep a history of the most recent CYCLES samples.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[CYCLES-2:0], lvl_i};
        end
    end

    // Move the output only on a unanimous history that disagrees with it.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            filt_q <= 1'b1;
        end else if (all_hi && !filt_q) begin
            filt_q <= 1'b1;
        end else if (all_lo && filt_q) begin
            filt_q <= 1'b0;
        end
    end

    assign filt_o = filt_q;

endmodule

// File: rtl/rst_bounce_filter.sv
// Module: rst_bounce_filter
// Cleans a noisy reset request before it enters an asynchronous reset
// synchronizer. The request is synchronized, normalized to active high and
// then accepted only after FILTER_CYCLES stable samples in either direction.
// Assumes: clk_i is free running and does not depend on the filtered reset;
// rst_req_o drives a reset synchronizer input, never flop reset pins.
module rst_bounce_filter #(
    parameter int unsigned       FILTER_CYCLES  = 8,
    parameter int unsigned       SYNC_STAGES    = 2,
    parameter bit                RAW_ACTIVE_LOW = 1'b1,
    parameter rbf_pkg::rbf_win_e WINDOW         = rbf_pkg::WIN_COUNT
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic raw_rst_i,
    output logic rst_req_o
);

    logic req_sync;

    // Metastability guard and polarity normalization.
    rbf_in_sync #(
        .STAGES     (SYNC_STAGES),
        .ACTIVE_LOW (RAW_ACTIVE_LOW)
    ) in_sync_i (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .raw_i   (raw_rst_i),
        .req_o   (req_sync)
    );

    // Pick the window implementation from the parameter.
    generate
        if (WINDOW == rbf_pkg::WIN_COUNT) begin : g_count
            rbf_cnt_win #(
                .CYCLES (FILTER_CYCLES)
            ) win_i (
                .clk_i   (clk_i),
                .por_n_i (por_n_i),
                .lvl_i   (req_sync),
                .filt_o  (rst_req_o)
            );
        end else begin : g_shift
            rbf_shift_win #(
                .CYCLES (FILTER_CYCLES)
            ) win_i (
                .clk_i   (clk_i),
                .por_n_i (por_n_i),
                .lvl_i   (req_sync),
                .filt_o  (rst_req_o)
            );
        end
    endgenerate

endmodule

// File: rtl/rbf_chk.sv
// Module: rbf_chk
// Property checker for rst_bounce_filter, attached with bind. It watches the
// synchronized request and the filtered output, and it keeps its own run
// counter of consecutive samples in which they disagree.
// Assumes: CYCLES >= 2.
module rbf_chk #(
    parameter int unsigned CYCLES = 8
) (
    input logic clk_i,
    input logic por_n_i,
    input logic sync_lvl,
    input logic filt
);

    localparam int unsigned RUN_W = $clog2(CYCLES + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(CYCLES);
    localparam logic [RUN_W-1:0] RUN_NEED = RUN_W'(CYCLES - 1);

    logic [RUN_W-1:0] run_q;

    // Count consecutive samples where the request disagrees with the output.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            run_q <= '0;
        end else if (sync_lvl == filt) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    por_assert_chk: assert property (@(posedge clk_i)
        !por_n_i |=> filt);

    // R6
    min_run_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(filt) |-> ($past(run_q) >= RUN_NEED));

    // R6
    new_level_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(filt) |-> ($past(sync_lvl, 2) == filt));

    // R6
    no_double_toggle_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(filt) |=> $stable(filt));

endmodule

bind rst_bounce_filter rbf_chk #(
    .CYCLES (FILTER_CYCLES)
) chk_i (
    .clk_i    (clk_i),
    .por_n_i  (por_n_i),
    .sync_lvl (req_sync),
    .filt     (rst_req_o)
);

// File: tb/rst_bounce_filter_tb_top.sv
// Bench for rst_bounce_filter: both window implementations on shared stimulus.
module rst_bounce_filter_tb_top;

    localparam int unsigned N       = 8;
    localparam int unsigned LAT_MAX = N + 3;
    localparam int unsigned WDOG    = 20000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic raw = 1'b1;      // active low: 1 = released
    logic out_c;
    logic out_s;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rst_bounce_filter #(
        .FILTER_CYCLES (N),
        .WINDOW        (rbf_pkg::WIN_COUNT)
    ) dut_i (
        .clk_i     (clk),
        .por_n_i   (por_n),
        .raw_rst_i (raw),
        .rst_req_o (out_c)
    );

    rst_bounce_filter #(
        .FILTER_CYCLES (N),
        .WINDOW        (rbf_pkg::WIN_SHIFT)
    ) dut_s_i (
        .clk_i     (clk),
        .por_n_i   (por_n),
        .raw_rst_i (raw),
        .rst_req_o (out_s)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // R1: forced asserted level under power-on clear.
    task automatic t_por_hold(input string tag);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " count"}, out_c, 1'b1);
        check({tag, " shift"}, out_s, 1'b1);
    endtask

    // Drive a new raw level and measure the cycles until each output moves.
    task automatic t_hold(input string tag, input logic lvl, input logic exp_out);
        int lat_c = -1;
        int lat_s = -1;
        raw = lvl;
        for (int k = 1; k <= int'(N) + 8; k++) begin
            @(negedge clk);
            if (lat_c < 0 && out_c == exp_out) lat_c = k;
            if (lat_s < 0 && out_s == exp_out) lat_s = k;
        end
        check_range({tag, " count latency"}, lat_c, N, LAT_MAX);
        check_range({tag, " shift latency"}, lat_s, N, LAT_MAX);
        check({tag, " R8 agree"}, out_c, out_s);
    endtask

    // Short pulse to level lvl for len cycles; the output must stay at keep.
    task automatic t_pulse(input string tag, input logic lvl, input int len, input logic keep);
        logic moved = 1'b0;
        raw = lvl;
        repeat (len) begin
            @(negedge clk);
            if (out_c != keep || out_s != keep) moved = 1'b1;
        end
        raw = ~lvl;
        repeat (N + 6) begin
            @(negedge clk);
            if (out_c != keep || out_s != keep) moved = 1'b1;
        end
        check(tag, moved, 1'b0);
    endtask

    // Train of sub-window pulses, ending at the starting level.
    task automatic t_train(input string tag, input logic lvl, input logic keep);
        logic moved = 1'b0;
        for (int p = 0; p < 6; p++) begin
            raw = lvl;
            repeat (N - 1) begin
                @(negedge clk);
                if (out_c != keep || out_s != keep) moved = 1'b1;
            end
            raw = ~lvl;
            repeat (1 + p % 3) begin
                @(negedge clk);
                if (out_c != keep || out_s != keep) moved = 1'b1;
            end
        end
        repeat (N + 6) begin
            @(negedge clk);
            if (out_c != keep || out_s != keep) moved = 1'b1;
        end
        check(tag, moved, 1'b0);
    endtask

    // Measure release latency from the rise of the power-on clear.
    task automatic t_por_release(input string tag);
        int lat_c = -1;
        int lat_s = -1;
        raw = 1'b1;
        @(negedge clk);
        por_n = 1'b1;
        for (int k = 1; k <= int'(N) + 8; k++) begin
            @(negedge clk);
            if (lat_c < 0 && out_c == 1'b0) lat_c = k;
            if (lat_s < 0 && out_s == 1'b0) lat_s = k;
        end
        check_range({tag, " count"}, lat_c, N, LAT_MAX);
        check_range({tag, " shift"}, lat_s, N, LAT_MAX);
    endtask

    initial begin
        t_por_hold("R1 power-on clear");
        t_por_release("R1 R5 release after clear");
        // R2 R4: active-low assertion pulses (raw 0) shorter than window
        t_pulse("R4 R2 assert pulse 1", 1'b0, 1, 1'b0);
        t_pulse("R4 assert pulse N/2", 1'b0, N / 2, 1'b0);
        t_pulse("R4 assert pulse N-1", 1'b0, N - 1, 1'b0);
        t_train("R4 assert bounce train", 1'b0, 1'b0);
        // R7 R2: held raw 0 asserts the active-high output
        t_hold("R7 R2 assert hold", 1'b0, 1'b1);
        // R3: release pulses while asserted
        t_pulse("R3 release pulse 1", 1'b1, 1, 1'b1);
        t_pulse("R3 release pulse N-1", 1'b1, N - 1, 1'b1);
        t_train("R3 release bounce train", 1'b1, 1'b1);
        // R5: held release
        t_hold("R5 release hold", 1'b1, 1'b0);
        // R1: clear in mid-operation from the released state
        t_por_hold("R1 mid-run clear");
        t_por_release("R1 R8 second release");
        check("R8 final agree", out_c, out_s);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule